// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits beside a flash array's write engine and produces what the host sees while an internal program or erase is in progress. It accepts already-decoded operation commands and one strobe per internal pulse from the array engine. From these it keeps track of the running operation: program or erase, the target sector, the top data bit being written, and how many pulses have been tried and how many succeeded. It then presents a status word and an active-low busy line.

Host reads are given as a strobe with the sector that the read address falls in. While the block claims a read, the block marks it with `status_sel`, and the array data path must return `status_word` in place of stored data. The polarity bit, the two toggle bits and the timeout bit follow the usual flash polling rules. Erase and program can each be suspended and resumed. When the pulse budget runs out, the block stays in a failed state until a clear command arrives.

Top module: `flash_op_status`

## Requirements
- R1: A program command on an unprotected sector makes the block busy and claims every read. Bit 7 of the status word reads as the complement of the written data bit. The first pulse with `pulse_ok` high ends the operation, and the status word then reads 0. Command codes are 1 program, 2 erase, 3 suspend, 4 resume, 5 clear, and 0 or 6..7 do nothing.
- R2: Bit 6 of the status word inverts after every read strobe taken while an operation is running, in program, erase, protected window or failed state. Cycles without a read leave it unchanged.
- R3: A program or erase aimed at a protected sector (`cmd_prot` high) keeps the block busy for exactly GUARD_CYC cycles. During that window bit 6 toggles on reads and no pulse is counted, and afterwards the block is idle.
- R4: If TRY_LIMIT pulses are tried without the operation completing, the block enters the failed state. There bit 5 reads 1 and `busy_n` stays low.
- R5: Bit 2 inverts only on reads of an erase operation (running, suspended or failed) whose `rd_sector` equals the sector being erased. Reads of any other sector leave it unchanged.
- R6: `busy_n` is low in the program, erase, protected-window and failed states, and high after reset, when idle and when suspended. After reset the status word is 0 and `status_sel` is low.
- R7: An erase finishes on the pulse that brings the count of successful pulses to GOOD_PULSES. Failed pulses add only to the tried count. During an erase bit 7 reads 0.
- R8: In program suspend the block is not busy and claims no read. Neither toggle bit changes and pulses are ignored. A resume returns to program with both toggles as they were.
- R9: In erase suspend pulses are ignored and both counts are held, and a resume continues from the held counts. A read of the erasing sector is claimed with bit 7 at 1, bit 2 toggling and bit 6 steady. A read of any other sector is not claimed.
- R10: The failed state ignores every command except clear, which returns the block to idle.
- R11: A command that does not apply to the current state is ignored. A suspend issued together with a pulse wins, and that pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 3 | Decoded operation command, one cycle per command |
| cmd_sector | input | SECT_W | Target sector of a program or erase command |
| cmd_d7 | input | 1 | Bit 7 of the data being programmed |
| cmd_prot | input | 1 | Target sector is protected |
| pulse_tick | input | 1 | Array engine finished one internal pulse |
| pulse_ok | input | 1 | That pulse succeeded (qualified by pulse_tick) |
| rd_en | input | 1 | Host read strobe |
| rd_sector | input | SECT_W | Sector of the host read address |
| status_word | output | 8 | Status returned when status_sel is high, else 0 |
| status_sel | output | 1 | Read returns status instead of array data |
| busy_n | output | 1 | Low while an operation occupies the block |

## Verification
The hardest situations to reach are those deep inside long pulse sequences: an erase suspended partway through its 300 good pulses, and an attempt count that reaches its limit. The stimulus drives hundreds of pulse strobes, with failing pulses mixed in, and parks the block in erase suspend halfway. There it sends pulses that must be ignored and reads both the erasing and a foreign sector before resuming. A separate run feeds 400 failing pulses so that the failed state is reached, and then tries commands that must bounce off it.

// File: rtl/flash_stat_pkg.sv
// Shared types for the embedded-operation status reporter.
// Assumes the command codes are produced by an upstream command decoder.
package flash_stat_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_ERASE, ST_GUARD, ST_PSUSP, ST_ESUSP, ST_FAIL
    } op_state_t;

    localparam logic [2:0] CMD_PROG   = 3'd1;
    localparam logic [2:0] CMD_ERASE  = 3'd2;
    localparam logic [2:0] CMD_SUSP   = 3'd3;
    localparam logic [2:0] CMD_RESUME = 3'd4;
    localparam logic [2:0] CMD_CLEAR  = 3'd5;

    localparam int BIT_POLL     = 7;
    localparam int BIT_TOG      = 6;
    localparam int BIT_TMO      = 5;
    localparam int BIT_SECT_TOG = 2;
endpackage

// File: rtl/fos_pulse_count.sv
// Counts tried and successful internal pulses of the running operation.
// Assumes: clear is asserted on the cycle an operation starts; count_en is
// low while suspended or not running, so counts are held there.
module fos_pulse_count #(
    parameter int GOOD_TARGET = 300,
    parameter int TRY_LIMIT   = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic tick,
    input  logic ok,
    output logic good_hit,
    output logic limit_hit
);
    localparam int TW = $clog2(TRY_LIMIT + 1);
    localparam int GW = $clog2(GOOD_TARGET + 1);

    logic [TW-1:0] tries_q;
    logic [GW-1:0] good_q;
    logic          step;

    assign step      = count_en && tick;
    assign good_hit  = step && ok && (good_q == GW'(GOOD_TARGET - 1));
    assign limit_hit = step && (tries_q == TW'(TRY_LIMIT - 1));

    // Purpose: advance both counts on each accepted pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tries_q <= '0;
            good_q  <= '0;
        end else if (step) begin
            if (tries_q != TW'(TRY_LIMIT)) tries_q <= tries_q + 1'b1;
            if (ok && good_q != GW'(GOOD_TARGET)) good_q <= good_q + 1'b1;
        end
    end

    AST_LIMIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit && !good_hit |=> !count_en);  // R4
    AST_GOOD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        good_hit |=> !count_en);  // R7
endmodule

// File: rtl/fos_sequencer.sv
// Operation state machine: start, protected window, suspend/resume,
// completion, failure and clear. Latches the operation's kind, sector and
// data bit. Assumes at most one command per cycle.
module fos_sequencer
    import flash_stat_pkg::*;
#(
    parameter int SECT_W    = 6,
    parameter int GUARD_CYC = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [SECT_W-1:0] cmd_sector,
    input  logic              cmd_d7,
    input  logic              cmd_prot,
    input  logic              tick,
    input  logic              ok,
    input  logic              good_hit,
    input  logic              limit_hit,
    output op_state_t         state,
    output logic              op_erase,
    output logic              op_d7,
    output logic [SECT_W-1:0] op_sector,
    output logic              cnt_clear,
    output logic              cnt_en
);
    localparam int WW = (GUARD_CYC > 1) ? $clog2(GUARD_CYC) : 1;

    op_state_t     state_q, state_d;
    logic [WW-1:0] win_q;
    logic          start_ok;

    assign start_ok  = (state_q == ST_IDLE) && (cmd == CMD_PROG || cmd == CMD_ERASE);
    assign cnt_clear = start_ok && !cmd_prot;
    assign cnt_en    = (state_q == ST_PROG || state_q == ST_ERASE) && (cmd != CMD_SUSP);
    assign state     = state_q;

    // Purpose: choose the next operation state.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_ok)
                          state_d = cmd_prot ? ST_GUARD
                                  : ((cmd == CMD_ERASE) ? ST_ERASE : ST_PROG);
            ST_PROG:  if (cmd == CMD_SUSP)    state_d = ST_PSUSP;
                      else if (tick && ok)    state_d = ST_IDLE;
                      else if (limit_hit)     state_d = ST_FAIL;
            ST_ERASE: if (cmd == CMD_SUSP)    state_d = ST_ESUSP;
                      else if (good_hit)      state_d = ST_IDLE;
                      else if (limit_hit)     state_d = ST_FAIL;
            ST_GUARD: if (win_q == '0)        state_d = ST_IDLE;
            ST_PSUSP: if (cmd == CMD_RESUME)  state_d = ST_PROG;
            ST_ESUSP: if (cmd == CMD_RESUME)  state_d = ST_ERASE;
            ST_FAIL:  if (cmd == CMD_CLEAR)   state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // Purpose: register the state and run the protected-target window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok && cmd_prot)                    win_q <= WW'(GUARD_CYC - 1);
            else if (state_q == ST_GUARD && win_q != '0) win_q <= win_q - 1'b1;
        end
    end

    // Purpose: capture the attributes of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_erase  <= 1'b0;
            op_d7     <= 1'b0;
            op_sector <= '0;
        end else if (start_ok) begin
            op_erase  <= (cmd == CMD_ERASE);
            op_d7     <= cmd_d7;
            op_sector <= cmd_sector;
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FAIL && cmd != CMD_CLEAR |=> state_q == ST_FAIL);  // R10
    AST_GUARD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_GUARD |=> state_q == ST_GUARD || state_q == ST_IDLE);  // R3
    AST_SUSP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ERASE && cmd == CMD_SUSP |=> state_q == ST_ESUSP);  // R11
endmodule

// File: rtl/fos_toggle.sv
// The two read-driven toggle bits. Each inverts on a read while its
// enable is high. Assumes enables are derived from the current state.
module fos_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic run_en,
    input  logic sect_en,
    output logic t_run,
    output logic t_sect
);
    // Purpose: invert each toggle on an enabled read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_run  <= 1'b0;
            t_sect <= 1'b0;
        end else if (rd_en) begin
            if (run_en)  t_run  <= !t_run;
            if (sect_en) t_sect <= !t_sect;
        end
    end
endmodule

// File: rtl/flash_op_status.sv
// Top of the embedded-operation status reporter. Combines the sequencer,
// pulse counter and toggles into the status word, read claim and busy line.
// Assumes the array engine raises pulse_tick once per completed pulse.
module flash_op_status
    import flash_stat_pkg::*;
#(
    parameter int SECT_W      = 6,
    parameter int GOOD_PULSES = 300,
    parameter int TRY_LIMIT   = 400,
    parameter int GUARD_CYC   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_code,
    input  logic [SECT_W-1:0] cmd_sector,
    input  logic              cmd_d7,
    input  logic              cmd_prot,
    input  logic              pulse_tick,
    input  logic              pulse_ok,
    input  logic              rd_en,
    input  logic [SECT_W-1:0] rd_sector,
    output logic [7:0]        status_word,
    output logic              status_sel,
    output logic              busy_n
);
    op_state_t         state;
    logic              op_erase, op_d7, cnt_clear, cnt_en, good_hit, limit_hit;
    logic [SECT_W-1:0] op_sector;
    logic              active, hit_sector, sect_en, t_run, t_sect;

    fos_sequencer #(.SECT_W(SECT_W), .GUARD_CYC(GUARD_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_code), .cmd_sector(cmd_sector),
        .cmd_d7(cmd_d7), .cmd_prot(cmd_prot), .tick(pulse_tick), .ok(pulse_ok),
        .good_hit(good_hit), .limit_hit(limit_hit), .state(state),
        .op_erase(op_erase), .op_d7(op_d7), .op_sector(op_sector),
        .cnt_clear(cnt_clear), .cnt_en(cnt_en)
    );

    fos_pulse_count #(.GOOD_TARGET(GOOD_PULSES), .TRY_LIMIT(TRY_LIMIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .count_en(cnt_en),
        .tick(pulse_tick), .ok(pulse_ok), .good_hit(good_hit), .limit_hit(limit_hit)
    );

    assign active     = (state == ST_PROG) || (state == ST_ERASE)
                     || (state == ST_GUARD) || (state == ST_FAIL);
    assign hit_sector = (rd_sector == op_sector);
    assign sect_en    = op_erase && hit_sector
                     && (state == ST_ERASE || state == ST_ESUSP || state == ST_FAIL);

    fos_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .run_en(active),
        .sect_en(sect_en), .t_run(t_run), .t_sect(t_sect)
    );

    assign status_sel = active || (state == ST_ESUSP && hit_sector);
    assign busy_n     = !active;

    // Purpose: assemble the status word for a claimed read.
    always_comb begin
        status_word = '0;
        if (status_sel) begin
            status_word[BIT_POLL]     = op_erase ? (state == ST_ESUSP) : !op_d7;
            status_word[BIT_TOG]      = t_run;
            status_word[BIT_TMO]      = (state == ST_FAIL);
            status_word[BIT_SECT_TOG] = t_sect;
        end
    end

    AST_FAIL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[BIT_TMO] |-> !busy_n);  // R4
    AST_QUIET_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(t_run) && $stable(t_sect));  // R2
    AST_OTHER_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !hit_sector |=> $stable(t_sect));  // R5
    AST_PSUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PSUSP |=> $stable(t_run) && $stable(t_sect));  // R8
endmodule

// File: tb/test_flash_op_status.sv
// Bench: behavioural reference model compared against the design every cycle.
module test_flash_op_status;
    localparam int SW = 6, GP = 300, TL = 400, GC = 50;
    localparam int M_IDLE = 0, M_PROG = 1, M_ERASE = 2, M_GUARD = 3,
                   M_PSUSP = 4, M_ESUSP = 5, M_FAIL = 6;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [2:0]    cmd_code = '0;
    logic [SW-1:0] cmd_sector = '0, rd_sector = '0;
    logic          cmd_d7 = 1'b0, cmd_prot = 1'b0;
    logic          pulse_tick = 1'b0, pulse_ok = 1'b0, rd_en = 1'b0;
    logic [7:0]    status_word;
    logic          status_sel, busy_n;

    flash_op_status #(.SECT_W(SW), .GOOD_PULSES(GP), .TRY_LIMIT(TL), .GUARD_CYC(GC))
    i_flash_op_status (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_sector(cmd_sector),
        .cmd_d7(cmd_d7), .cmd_prot(cmd_prot), .pulse_tick(pulse_tick),
        .pulse_ok(pulse_ok), .rd_en(rd_en), .rd_sector(rd_sector),
        .status_word(status_word), .status_sel(status_sel), .busy_n(busy_n)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0, n_bad = 0;
    string tag = "R6";
    int    ms = M_IDLE, msec = 0, matt = 0, mgood = 0, mwin = 0;
    bit    mer = 0, md7 = 0, mt6 = 0, mt2 = 0;

    function automatic bit m_active();
        return ms == M_PROG || ms == M_ERASE || ms == M_GUARD || ms == M_FAIL;
    endfunction

    task automatic cmp(string what, logic [7:0] got, logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_now();
        bit sel;
        logic [7:0] w;
        sel = m_active() || (ms == M_ESUSP && int'(rd_sector) == msec);
        w = '0;
        if (sel) begin
            w[7] = mer ? (ms == M_ESUSP) : !md7;
            w[6] = mt6;
            w[5] = (ms == M_FAIL);
            w[2] = mt2;
        end
        cmp("busy_n", {7'd0, busy_n}, {7'd0, !m_active()});
        cmp("status_sel", {7'd0, status_sel}, {7'd0, sel});
        cmp("status_word", status_word, w);
    endtask

    task automatic model_step();
        bit f6, f2;
        if (!rst_n) begin
            ms = M_IDLE; mer = 0; md7 = 0; msec = 0; mt6 = 0; mt2 = 0;
            matt = 0; mgood = 0; mwin = 0;
            return;
        end
        f6 = rd_en && m_active();
        f2 = rd_en && mer && int'(rd_sector) == msec
             && (ms == M_ERASE || ms == M_ESUSP || ms == M_FAIL);
        if (f6) mt6 = !mt6;
        if (f2) mt2 = !mt2;
        case (ms)
            M_IDLE: if (cmd_code == 1 || cmd_code == 2) begin
                mer = (cmd_code == 2); md7 = cmd_d7; msec = int'(cmd_sector);
                if (cmd_prot) begin ms = M_GUARD; mwin = GC; end
                else begin ms = mer ? M_ERASE : M_PROG; matt = 0; mgood = 0; end
            end
            M_PROG: if (cmd_code == 3) ms = M_PSUSP;
                else if (pulse_tick) begin
                    matt++;
                    if (pulse_ok) ms = M_IDLE;
                    else if (matt == TL) ms = M_FAIL;
                end
            M_ERASE: if (cmd_code == 3) ms = M_ESUSP;
                else if (pulse_tick) begin
                    matt++;
                    if (pulse_ok) mgood++;
                    if (mgood == GP) ms = M_IDLE;
                    else if (matt == TL) ms = M_FAIL;
                end
            M_GUARD: begin mwin--; if (mwin == 0) ms = M_IDLE; end
            M_PSUSP: if (cmd_code == 4) ms = M_PROG;
            M_ESUSP: if (cmd_code == 4) ms = M_ERASE;
            M_FAIL:  if (cmd_code == 5) ms = M_IDLE;
            default: ms = M_IDLE;
        endcase
    endtask

    task automatic cyc();
        #5 check_now();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmd_code = 0; pulse_tick = 0; pulse_ok = 0; rd_en = 0; cmd_prot = 0;
    endtask

    task automatic issue(int c, int sec, bit d7, bit prot);
        cmd_code = 3'(c); cmd_sector = SW'(sec); cmd_d7 = d7; cmd_prot = prot;
        cyc();
    endtask

    task automatic rd(int sec);
        rd_en = 1; rd_sector = SW'(sec);
        cyc();
    endtask

    task automatic pulse(bit good);
        pulse_tick = 1; pulse_ok = good;
        cyc();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(posedge clk); model_step(); @(negedge clk);
        tag = "R6"; cyc(); cyc();               // reset state
        rst_n = 1; cyc();

        tag = "R1";                             // program, data bit 7 = 1
        issue(1, 4, 1'b1, 1'b0);
        tag = "R2"; rd(4); rd(0); cyc(); rd(9);
        tag = "R1"; pulse(0); pulse(0);
        rd_en = 1; rd_sector = 4; pulse(0);
        tag = "R11"; issue(2, 7, 1'b0, 1'b0); issue(5, 0, 1'b0, 1'b0); issue(4, 0, 1'b0, 1'b0);
        tag = "R1"; pulse(1); cyc(); rd(4);

        tag = "R3";                             // protected program window
        issue(1, 3, 1'b0, 1'b1);
        for (int i = 0; i < GC + 3; i++) begin
            if (i % 3 == 0) rd(3); else pulse(1);
        end

        tag = "R7";                             // erase sector 5
        issue(2, 5, 1'b0, 1'b0);
        tag = "R5"; rd(5); rd(3); rd(5); rd(5); rd(12);
        tag = "R7";
        for (int i = 0; i < 10; i++) pulse(0);
        for (int i = 0; i < 150; i++) begin
            if (i % 7 == 0) begin rd_en = 1; rd_sector = SW'(i % 2 ? 5 : 1); end
            pulse(1);
        end
        tag = "R11"; cmd_code = 3; pulse_tick = 1; pulse_ok = 1; cyc();
        tag = "R9";
        for (int i = 0; i < 5; i++) pulse(1);
        rd(5); rd(5); rd(3); rd(5); cyc();
        issue(4, 0, 1'b0, 1'b0);
        tag = "R7";
        for (int i = 0; i < 151; i++) pulse(1);
        cyc(); rd(5);

        tag = "R8";                             // program suspend, data bit 7 = 0
        issue(1, 8, 1'b0, 1'b0);
        rd(8); pulse(0);
        issue(3, 0, 1'b0, 1'b0);
        rd(8); rd(8); pulse(1); rd(2); cyc();
        issue(4, 0, 1'b0, 1'b0);
        rd(8); pulse(1); cyc();

        tag = "R4";                             // erase runs out of pulses
        issue(2, 2, 1'b0, 1'b0);
        for (int i = 0; i < TL; i++) begin
            if (i % 50 == 0) begin rd_en = 1; rd_sector = 2; end
            pulse(0);
        end
        cyc();
        tag = "R10";
        issue(1, 2, 1'b1, 1'b0); issue(4, 0, 1'b0, 1'b0); issue(3, 0, 1'b0, 1'b0);
        rd(2); rd(6); pulse(1);
        issue(5, 0, 1'b0, 1'b0);
        cyc(); rd(2);

        tag = "R6"; cyc();
        finish_run();
    end
endmodule